// File: doc/BRIEF.md
# Four-Switch Buck-Boost Mode Sequencer

This block is the digital controller for a non-inverting power stage built from two half-bridge legs around one inductor: an input leg (high-side and low-side switch on the supply side) and an output leg (high-side and low-side switch on the load side). It reads single-bit comparator flags from the analog front end and drives the four gate enables. The flags are output-feedback-above-window, inductor-at-peak, inductor-at-zero, current-below-boost-threshold and current-above-buck-threshold. It sleeps with every switch open while the output sits above its hysteresis window. When the output falls, it cycles the inductor current between zero and the peak limit.

The sequencer decides between buck and boost operation within a single switching cycle. It does not compare voltages. Instead it tests the inductor current at programmed delays after a phase begins, since the current slope reflects whether the input is above or below the output. Two checks run in each mode. The early check switches mode on the spot. The late check, taken when the current has not reached its target, switches mode for the next cycle. Every flag passes through a two-flop synchroniser. Every change in a leg inserts a programmable break-before-make gap.

Top module: `fsbb_mode_seq`

## Requirements
- R1: After reset all four gate outputs are 0 and `boost_o` is 0 (buck). While `fb_hi_i` is high the block stays asleep with all gates 0.
- R2: When `fb_hi_i` is low and the mode is buck, the block enters buck energise: input high-side and output high-side on (`in_hs_o`=1, `out_hs_o`=1, others 0).
- R3: In buck energise, `pk_i` moves the block to buck freewheel (`in_ls_o`=1, `out_hs_o`=1). In freewheel, `zc_i` returns it to the energise state of the current mode.
- R4: In buck energise, when the phase timer equals `bk_dly1_i`, `pk_i` is low and `below_bst_i` is high, the mode becomes boost (`boost_o`=1) and the block enters boost energise at once (`in_hs_o`=1, `out_ls_o`=1).
- R5: In buck energise, when the timer reaches `bk_dly2_i` without `pk_i`, the input high-side opens and the block goes to freewheel (`in_ls_o`=1, `out_hs_o`=1). It also sets `boost_o`=1, so the energise phase after `zc_i` is boost energise.
- R6: In boost mode, `pk_i` moves boost energise to boost de-energise (`in_hs_o`=1, `out_hs_o`=1). `zc_i` moves de-energise back to boost energise.
- R7: In boost de-energise, when the timer equals `bs_dly1_i`, `zc_i` is low and `above_bk_i` is high, the mode becomes buck (`boost_o`=0) and the block enters buck freewheel at once.
- R8: In boost de-energise, when the timer reaches `bs_dly2_i` without `zc_i`, `boost_o` clears. The energise phase after `zc_i` is then buck energise, and `pk_i` from there leads to buck freewheel.
- R9: From any active state, a high `fb_hi_i` returns the block to sleep with all gates 0. The mode is kept.
- R10: Both switches of one leg are never on together. On every change of a leg, both of its switches are off for exactly `dead_i`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_hi_i | input | 1 | Output feedback above hysteresis window |
| pk_i | input | 1 | Inductor current at peak limit |
| zc_i | input | 1 | Inductor current at zero |
| below_bst_i | input | 1 | Inductor current below boost threshold |
| above_bk_i | input | 1 | Inductor current above buck threshold |
| bk_dly1_i | input | DLY_W | Buck-mode early check delay, clocks |
| bk_dly2_i | input | DLY_W | Buck-mode late check delay, clocks |
| bs_dly1_i | input | DLY_W | Boost-mode early check delay, clocks |
| bs_dly2_i | input | DLY_W | Boost-mode late check delay, clocks |
| dead_i | input | DEAD_W | Dead time, clocks minus one |
| in_hs_o | output | 1 | Input leg high-side gate enable |
| in_ls_o | output | 1 | Input leg low-side gate enable |
| out_hs_o | output | 1 | Output leg high-side gate enable |
| out_ls_o | output | 1 | Output leg low-side gate enable |
| boost_o | output | 1 | Current mode: 1 boost, 0 buck |

## Verification
The hardest conditions to reach are the late-check paths (R5, R8). The phase timer must pass the late delay while the peak or zero flag stays quiet. Both early checks must also fail, even though the early delay falls in the same phase. The bench sets the early delays well inside the late ones and holds the slope comparator low. It then waits past the late delay in one phase and confirms the mode change. It does this first through the freewheel pattern and then through the energise state that the next cycle picks.

// File: rtl/fsbb_pkg.sv
package fsbb_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP   = 3'd0,
        ST_BK_ON   = 3'd1,
        ST_BK_FW   = 3'd2,
        ST_BST_ON  = 3'd3,
        ST_BST_OFF = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    localparam int unsigned NUM_LEGS = 2;
    localparam int unsigned LEG_IN   = 0;
    localparam int unsigned LEG_OUT  = 1;
endpackage

// File: rtl/fsbb_sync.sv
module fsbb_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = d_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o = r_q.s2;
endmodule

// File: rtl/fsbb_deadtime.sv
module fsbb_deadtime
    import fsbb_pkg::*;
#(
    parameter int unsigned DEAD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEAD_W-1:0] dead_i,
    input  leg_t              req_i,
    output leg_t              gate_o
);
    typedef struct packed {
        leg_t              cur;
        logic [DEAD_W-1:0] cnt;
    } dt_t;

    dt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (req_i == r_q.cur) begin
            r_d.cnt = '0;
        end else if (r_q.cur != '0) begin
            r_d.cur = '0;
            r_d.cnt = '0;
        end else if (r_q.cnt >= dead_i) begin
            r_d.cur = req_i;
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o = r_q.cur;
endmodule

// File: rtl/fsbb_mode_seq.sv
module fsbb_mode_seq
    import fsbb_pkg::*;
#(
    parameter int unsigned DLY_W  = 16,
    parameter int unsigned DEAD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_hi_i,
    input  logic              pk_i,
    input  logic              zc_i,
    input  logic              below_bst_i,
    input  logic              above_bk_i,
    input  logic [DLY_W-1:0]  bk_dly1_i,
    input  logic [DLY_W-1:0]  bk_dly2_i,
    input  logic [DLY_W-1:0]  bs_dly1_i,
    input  logic [DLY_W-1:0]  bs_dly2_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              in_hs_o,
    output logic              in_ls_o,
    output logic              out_hs_o,
    output logic              out_ls_o,
    output logic              boost_o
);
    localparam int unsigned NFLAG = 5;
    localparam logic [DLY_W-1:0] TMR_MAX = '1;
    localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'(1);

    typedef struct packed {
        seq_state_t       state;
        logic             boost;
        logic [DLY_W-1:0] timer;
    } seq_t;

    logic [NFLAG-1:0] flag_s;
    logic fb_s, pk_s, zc_s, blw_s, abv_s;
    seq_t q_r, q_d;
    leg_t req [NUM_LEGS];
    leg_t gate [NUM_LEGS];

    fsbb_sync #(.W(NFLAG), .RST_VAL(FLAG_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({above_bk_i, below_bst_i, zc_i, pk_i, fb_hi_i}),
        .q_o   (flag_s)
    );

    assign {abv_s, blw_s, zc_s, pk_s, fb_s} = flag_s;

    always_comb begin
        q_d = q_r;
        unique case (q_r.state)
            ST_SLEEP: begin
                if (!fb_s) q_d.state = q_r.boost ? ST_BST_ON : ST_BK_ON;
            end
            ST_BK_ON: begin
                if (fb_s) begin
                    q_d.state = ST_SLEEP;
                end else if (pk_s) begin
                    q_d.state = ST_BK_FW;
                end else if (q_r.timer == bk_dly1_i && blw_s) begin
                    q_d.boost = 1'b1;
                    q_d.state = ST_BST_ON;
                end else if (q_r.timer == bk_dly2_i) begin
                    q_d.boost = 1'b1;
                    q_d.state = ST_BK_FW;
                end
            end
            ST_BK_FW: begin
                if (fb_s) q_d.state = ST_SLEEP;
                else if (zc_s) q_d.state = q_r.boost ? ST_BST_ON : ST_BK_ON;
            end
            ST_BST_ON: begin
                if (fb_s) q_d.state = ST_SLEEP;
                else if (pk_s) q_d.state = ST_BST_OFF;
            end
            ST_BST_OFF: begin
                if (fb_s) begin
                    q_d.state = ST_SLEEP;
                end else if (zc_s) begin
                    q_d.state = q_r.boost ? ST_BST_ON : ST_BK_ON;
                end else if (q_r.timer == bs_dly1_i && abv_s) begin
                    q_d.boost = 1'b0;
                    q_d.state = ST_BK_FW;
                end else if (q_r.timer == bs_dly2_i) begin
                    q_d.boost = 1'b0;
                end
            end
            default: q_d.state = ST_SLEEP;
        endcase

        if (q_d.state != q_r.state) q_d.timer = '0;
        else if (q_r.timer != TMR_MAX) q_d.timer = q_r.timer + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '{state: ST_SLEEP, boost: 1'b0, timer: '0};
        end else begin
            q_r <= q_d;
        end
    end

    always_comb begin
        req[LEG_IN]  = '0;
        req[LEG_OUT] = '0;
        unique case (q_r.state)
            ST_BK_ON:   begin req[LEG_IN].hi = 1'b1; req[LEG_OUT].hi = 1'b1; end
            ST_BK_FW:   begin req[LEG_IN].lo = 1'b1; req[LEG_OUT].hi = 1'b1; end
            ST_BST_ON:  begin req[LEG_IN].hi = 1'b1; req[LEG_OUT].lo = 1'b1; end
            ST_BST_OFF: begin req[LEG_IN].hi = 1'b1; req[LEG_OUT].hi = 1'b1; end
            default:    ;
        endcase
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        fsbb_deadtime #(.DEAD_W(DEAD_W)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .dead_i (dead_i),
            .req_i  (req[g]),
            .gate_o (gate[g])
        );
    end

    assign in_hs_o  = gate[LEG_IN].hi;
    assign in_ls_o  = gate[LEG_IN].lo;
    assign out_hs_o = gate[LEG_OUT].hi;
    assign out_ls_o = gate[LEG_OUT].lo;
    assign boost_o  = q_r.boost;
endmodule

// File: rtl/fsbb_mode_seq_chk.sv
module fsbb_mode_seq_chk
    import fsbb_pkg::*;
#(
    parameter int unsigned DLY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fb_s,
    input logic             pk_s,
    input logic             zc_s,
    input logic             blw_s,
    input logic             abv_s,
    input seq_state_t       state,
    input logic             boost,
    input logic [DLY_W-1:0] timer,
    input logic [DLY_W-1:0] bk_dly1,
    input logic [DLY_W-1:0] bs_dly1,
    input logic             in_hs,
    input logic             in_ls,
    input logic             out_hs,
    input logic             out_ls
);
    AST_IN_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_hs && in_ls)); // R10
    AST_OUT_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hs && out_ls)); // R10
    AST_IN_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_hs) |-> !in_ls); // R10
    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> !(in_hs || in_ls || out_hs || out_ls)); // R1
    AST_FB_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_s && state != ST_SLEEP) |=> state == ST_SLEEP); // R9
    AST_BUCK_EARLY_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BK_ON && !fb_s && !pk_s && timer == bk_dly1 && blw_s) |=> (boost && state == ST_BST_ON)); // R4
    AST_BOOST_EARLY_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BST_OFF && !fb_s && !zc_s && timer == bs_dly1 && abv_s) |=> (!boost && state == ST_BK_FW)); // R7
endmodule

bind fsbb_mode_seq fsbb_mode_seq_chk #(.DLY_W(DLY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_s    (fb_s),
    .pk_s    (pk_s),
    .zc_s    (zc_s),
    .blw_s   (blw_s),
    .abv_s   (abv_s),
    .state   (q_r.state),
    .boost   (q_r.boost),
    .timer   (q_r.timer),
    .bk_dly1 (bk_dly1_i),
    .bs_dly1 (bs_dly1_i),
    .in_hs   (in_hs_o),
    .in_ls   (in_ls_o),
    .out_hs  (out_hs_o),
    .out_ls  (out_ls_o)
);

// File: tb/tb_fsbb_mode_seq.sv
module tb_fsbb_mode_seq;
    localparam int DLY_W  = 16;
    localparam int DEAD_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_hi = 1'b1, pk = 1'b0, zc = 1'b0, blw = 1'b0, abv = 1'b0;
    logic [DLY_W-1:0] bk1 = 16'd20, bk2 = 16'd40, bs1 = 16'd20, bs2 = 16'd40;
    logic [DEAD_W-1:0] dead = 6'd2;
    logic in_hs, in_ls, out_hs, out_ls, boost;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    fsbb_mode_seq #(.DLY_W(DLY_W), .DEAD_W(DEAD_W)) dut (
        .clk(clk), .rst_n(rst_n), .fb_hi_i(fb_hi), .pk_i(pk), .zc_i(zc),
        .below_bst_i(blw), .above_bk_i(abv),
        .bk_dly1_i(bk1), .bk_dly2_i(bk2), .bs_dly1_i(bs1), .bs_dly2_i(bs2),
        .dead_i(dead),
        .in_hs_o(in_hs), .in_ls_o(in_ls), .out_hs_o(out_hs), .out_ls_o(out_ls),
        .boost_o(boost)
    );

    // expected vector order: {in_hs, in_ls, out_hs, out_ls, boost}
    localparam logic [4:0] P_OFF_BK  = 5'b00000;
    localparam logic [4:0] P_BK_ON   = 5'b10100;
    localparam logic [4:0] P_BK_FW   = 5'b01100;
    localparam logic [4:0] P_BK_FW_B = 5'b01101;
    localparam logic [4:0] P_BST_ON  = 5'b10011;
    localparam logic [4:0] P_BST_OFF = 5'b10101;
    localparam logic [4:0] P_HH_BK   = 5'b10100;

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [4:0] act;
                it = sb_q.pop_front();
                act = {in_hs, in_ls, out_hs, out_ls, boost};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: outputs %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_out(input logic [4:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic check_gap(input int exp, input string tag);
        int gap = 0;
        pk = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (in_ls) break;
            if (!in_hs && !in_ls) gap++;
        end
        n_checks++;
        if (gap != exp || !in_ls) begin
            n_fail++;
            $display("FAIL %s: dead gap %0d expected %0d", tag, gap, exp);
        end
        pk = 1'b0;
    endtask

    initial begin
        wait_cyc(1);
        n_checks++;
        if ({in_hs, in_ls, out_hs, out_ls, boost} !== 5'b0) begin
            n_fail++;
            $display("FAIL R1 reset: %b expected 00000", {in_hs, in_ls, out_hs, out_ls, boost});
        end
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(10);
        expect_out(P_OFF_BK, "R1 sleep while feedback high");

        fb_hi = 1'b0;
        wait_cyc(10);
        expect_out(P_BK_ON, "R2 buck energise");
        pk = 1'b1; wait_cyc(10); pk = 1'b0;
        expect_out(P_BK_FW, "R3 buck freewheel on peak");
        zc = 1'b1; wait_cyc(10); zc = 1'b0;
        expect_out(P_BK_ON, "R3 back to energise on zero");

        blw = 1'b1; wait_cyc(30); blw = 1'b0;
        expect_out(P_BST_ON, "R4 early switch to boost");

        pk = 1'b1; wait_cyc(10); pk = 1'b0;
        expect_out(P_BST_OFF, "R6 boost de-energise on peak");
        zc = 1'b1; wait_cyc(10); zc = 1'b0;
        expect_out(P_BST_ON, "R6 boost energise on zero");

        pk = 1'b1; wait_cyc(10); pk = 1'b0;
        abv = 1'b1; wait_cyc(30); abv = 1'b0;
        expect_out(P_BK_FW, "R7 early switch to buck");
        zc = 1'b1; wait_cyc(10); zc = 1'b0;
        expect_out(P_BK_ON, "R7 buck energise follows");

        wait_cyc(50);
        expect_out(P_BK_FW_B, "R5 late check opens input high-side");
        zc = 1'b1; wait_cyc(10); zc = 1'b0;
        expect_out(P_BST_ON, "R5 next cycle boost energise");

        pk = 1'b1; wait_cyc(10); pk = 1'b0;
        wait_cyc(50);
        expect_out(P_HH_BK, "R8 late check clears boost");
        zc = 1'b1; wait_cyc(10); zc = 1'b0;
        pk = 1'b1; wait_cyc(10); pk = 1'b0;
        expect_out(P_BK_FW, "R8 next cycle is buck");

        fb_hi = 1'b1; wait_cyc(10);
        expect_out(P_OFF_BK, "R9 sleep from active state");

        fb_hi = 1'b0; wait_cyc(10);
        expect_out(P_BK_ON, "R9 wake keeps buck mode");
        check_gap(3, "R10 dead time 2");
        zc = 1'b1; wait_cyc(10); zc = 1'b0;
        dead = 6'd0;
        wait_cyc(5);
        check_gap(1, "R10 dead time 0");
        fb_hi = 1'b1; wait_cyc(10);
        expect_out(P_OFF_BK, "R9 final sleep");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule